// File: doc/BRIEF.md
# Address Walking-Ones Memory Tester

This engine checks the address path of a memory that sits behind a plain synchronous read/write port. It drives only addresses with exactly one bit set and exposes address lines that are shorted together or decode to the same word. For each ordered pair of address bits it writes a pattern to the first one-hot address. It then writes the bitwise complement of that pattern to the second one-hot address. Finally it reads the first address back. If the two lines alias, the second write lands on the first word and the read returns the complement.

Software or a test sequencer pulses `start` and waits for the one-cycle `done` pulse. `fail` shows the result. On the first mismatch the engine stops issuing requests and holds the failing address, the expected data and the returned data until the next run. Read data returns a fixed number of cycles after the read request, and that number is set by a parameter.

Top module: `addr_walk_tester`

## Requirements
- R1: After reset the engine is idle. `busy`, `done`, `fail`, `mem_we` and `mem_re` are low, and the capture outputs are zero.
- R2: Every request address has exactly one bit set. The single exception is the opening write to address zero.
- R3: The first address walks bit positions 0 up to AW-1 in ascending order. For each of them the second address takes every other bit position in ascending order. Each pair issues three requests in this order: a write of PATTERN to 1<<i, a write of ~PATTERN to 1<<j, and a read of 1<<i.
- R4: On a clean memory a run issues exactly 1 + 3·AW·(AW-1) requests. `done` then goes high for exactly one cycle and `fail` stays low.
- R5: Read data is compared in the cycle that starts RD_LAT clock edges after the edge that sampled `mem_re`. `busy` is therefore high for 1 + AW·(AW-1)·(3+RD_LAT) cycles in a clean run.
- R6: When the returned data differs from PATTERN, the engine does four things. It raises `fail`. It latches the one-hot read address into `err_addr`, PATTERN into `err_exp` and the returned data into `err_act`. It pulses `done`. It issues no further requests.
- R7: A `start` pulse while `busy` is high has no effect on the request stream or on the run length.
- R8: The first request of every run is a write of ~PATTERN to address zero.
- R9: `start` while idle clears `fail` and begins a new run from the first pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | Last run found an address fault |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data |
| mem_we | output | 1 | Write request |
| mem_re | output | 1 | Read request |
| mem_rdata | input | DW | Read data, valid RD_LAT edges after the read |
| err_addr | output | AW | Address of the first failing read |
| err_exp | output | DW | Data expected at the failing read |
| err_act | output | DW | Data returned at the failing read |

## Verification
The bench targets wired-OR and wired-AND shorts between randomly chosen address lines, including adjacent lines and the two extreme lines. A design with the wrong pair order or the wrong data polarity would report another address, or would miss the alias altogether. A tester that did not stop would keep issuing requests after the fault. A comparison made one cycle early or late would read stale data, and the `busy` length check would expose it. A `start` pulse in the middle of a run catches an engine that restarts. A clean run after a failing one catches a `fail` flag that does not clear.

// File: rtl/awt_pkg.sv
package awt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ZERO,
      ST_WRA,
      ST_WRB,
      ST_RD,
      ST_WAIT
   } awt_state_e;
endpackage

// File: rtl/awt_pair_seq.sv
// Walks the ordered pair (first, second) of distinct bit positions.
module awt_pair_seq #(
   parameter int AW = 8,
   localparam int IW = (AW > 1) ? $clog2(AW) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   output logic [IW-1:0] first_idx,
   output logic [IW-1:0] second_idx,
   output logic          last
);
   logic [IW:0] nf, ns;

   always_comb begin
      nf = {1'b0, first_idx};
      ns = {1'b0, second_idx} + 1'b1;
      if (ns == nf) ns = ns + 1'b1;
      if (ns >= (IW+1)'(AW)) begin
         nf = nf + 1'b1;
         ns = '0;
      end
   end

   assign last = (first_idx == IW'(AW-1)) && (second_idx == IW'(AW-2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_idx  <= '0;
         second_idx <= IW'(1);
      end else if (clear) begin
         first_idx  <= '0;
         second_idx <= IW'(1);
      end else if (step) begin
         first_idx  <= nf[IW-1:0];
         second_idx <= ns[IW-1:0];
      end
   end

   // R3
   distinct_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      first_idx != second_idx);
endmodule

// File: rtl/awt_rd_pipe.sv
// Tracks the outstanding read until its data is due at the port.
module awt_rd_pipe #(
   parameter int RD_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   output logic due
);
   logic [RD_LAT-1:0] sh;

   if (RD_LAT == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= issue;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[RD_LAT-2:0], issue};
      end
   end

   assign due = sh[RD_LAT-1];

   // R5
   single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sh) <= 1);
endmodule

// File: rtl/addr_walk_tester.sv
module addr_walk_tester
   import awt_pkg::*;
#(
   parameter int            AW      = 8,
   parameter int            DW      = 16,
   parameter int            RD_LAT  = 2,
   parameter logic [DW-1:0] PATTERN = 16'hA5C3,
   localparam int           IW      = (AW > 1) ? $clog2(AW) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic          fail,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_we,
   output logic          mem_re,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] err_addr,
   output logic [DW-1:0] err_exp,
   output logic [DW-1:0] err_act
);
   if (AW < 2)      begin : g_bad_aw  $error("AW must be at least 2");     end
   if (RD_LAT < 1)  begin : g_bad_lat $error("RD_LAT must be at least 1"); end
   if (DW < 2)      begin : g_bad_dw  $error("DW must be at least 2");     end

   awt_state_e      state;
   logic [IW-1:0]   first_idx, second_idx;
   logic            last_pair, rd_due, seq_clear, seq_step, mismatch;
   logic [AW-1:0]   first_hot, second_hot;

   assign first_hot  = AW'(1) << first_idx;
   assign second_hot = AW'(1) << second_idx;
   assign seq_clear  = (state == ST_IDLE) && start;
   assign seq_step   = (state == ST_WAIT) && rd_due && !mismatch && !last_pair;
   assign mismatch   = mem_rdata != PATTERN;

   awt_pair_seq #(.AW(AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .clear(seq_clear), .step(seq_step),
      .first_idx(first_idx), .second_idx(second_idx), .last(last_pair)
   );

   awt_rd_pipe #(.RD_LAT(RD_LAT)) u_rdp (
      .clk(clk), .rst_n(rst_n), .issue(mem_re), .due(rd_due)
   );

   always_comb begin
      mem_we    = (state == ST_ZERO) || (state == ST_WRA) || (state == ST_WRB);
      mem_re    = (state == ST_RD);
      mem_wdata = (state == ST_WRA) ? PATTERN : ~PATTERN;
      unique case (state)
         ST_ZERO: mem_addr = '0;
         ST_WRB:  mem_addr = second_hot;
         default: mem_addr = first_hot;
      endcase
   end

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         done     <= 1'b0;
         fail     <= 1'b0;
         err_addr <= '0;
         err_exp  <= '0;
         err_act  <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               fail  <= 1'b0;
               state <= ST_ZERO;
            end
            ST_ZERO: state <= ST_WRA;
            ST_WRA:  state <= ST_WRB;
            ST_WRB:  state <= ST_RD;
            ST_RD:   state <= ST_WAIT;
            ST_WAIT: if (rd_due) begin
               if (mismatch) begin
                  fail     <= 1'b1;
                  err_addr <= first_hot;
                  err_exp  <= PATTERN;
                  err_act  <= mem_rdata;
                  done     <= 1'b1;
                  state    <= ST_IDLE;
               end else if (last_pair) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  state <= ST_WRA;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2
   onehot_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_we || mem_re) && (state != ST_ZERO)) |-> $onehot(mem_addr));
   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6
   halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(mem_we || mem_re));
   // R6
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> (err_act != err_exp) && done);
   // R8
   zero_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> mem_we && (mem_addr == '0) && (mem_wdata == ~PATTERN));
   // R2
   excl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));
endmodule

// File: tb/sim_addr_walk_tester.sv
module sim_addr_walk_tester;
   localparam int            AW     = 8;
   localparam int            DW     = 16;
   localparam int            RD_LAT = 2;
   localparam logic [DW-1:0] PAT    = 16'hA5C3;
   localparam int            NPAIR  = AW * (AW - 1);
   localparam int            DEPTH  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          busy, done, fail, mem_we, mem_re;
   logic [AW-1:0] mem_addr, err_addr;
   logic [DW-1:0] mem_wdata, mem_rdata, err_exp, err_act;

   always #5 clk = ~clk;

   addr_walk_tester #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT), .PATTERN(PAT)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .fail(fail), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
      .err_addr(err_addr), .err_exp(err_exp), .err_act(err_act)
   );

   // faulty memory model: 0 none, 1 wired-OR short, 2 wired-AND short
   int fmode = 0, fa = 0, fb = 1;
   logic [DW-1:0] mem  [DEPTH];
   logic [DW-1:0] refm [DEPTH];
   logic [DW-1:0] rpipe[RD_LAT];

   function automatic logic [AW-1:0] phys(input logic [AW-1:0] a);
      logic [AW-1:0] p = a;
      logic v;
      if (fmode == 1) begin v = a[fa] | a[fb]; p[fa] = v; p[fb] = v; end
      if (fmode == 2) begin v = a[fa] & a[fb]; p[fa] = v; p[fb] = v; end
      return p;
   endfunction

   always @(posedge clk) begin
      if (mem_we) mem[phys(mem_addr)] <= mem_wdata;
      rpipe[0] <= mem[phys(mem_addr)];
      for (int k = 1; k < RD_LAT; k++) rpipe[k] <= rpipe[k-1];
   end
   assign mem_rdata = rpipe[RD_LAT-1];

   // expected request k of a run: {we, addr, data}
   function automatic logic [AW+DW:0] exp_txn(input int k);
      int p, m, i, r, j;
      if (k == 0) return {1'b1, AW'(0), ~PAT};
      p = (k - 1) / 3; m = (k - 1) % 3;
      i = p / (AW - 1); r = p % (AW - 1); j = (r < i) ? r : r + 1;
      if (m == 0) return {1'b1, AW'(1) << i, PAT};
      if (m == 1) return {1'b1, AW'(1) << j, ~PAT};
      return {1'b0, AW'(1) << i, DW'(0)};
   endfunction

   // reference run on the faulty map; returns failing pair or -1
   logic [DW-1:0] ref_act;
   function automatic int ref_first_fail();
      int i, r, j;
      refm[phys(AW'(0))] = ~PAT;
      for (int p = 0; p < NPAIR; p++) begin
         i = p / (AW - 1); r = p % (AW - 1); j = (r < i) ? r : r + 1;
         refm[phys(AW'(1) << i)] = PAT;
         refm[phys(AW'(1) << j)] = ~PAT;
         if (refm[phys(AW'(1) << i)] != PAT) begin
            ref_act = refm[phys(AW'(1) << i)];
            return p;
         end
      end
      return -1;
   endfunction

   int checks = 0, failures = 0;
   int txn_cnt = 0, order_err = 0, hot_err = 0, busy_cyc = 0, cyc = 0;
   bit mon_on = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
      if (mon_on) begin
         if (busy) busy_cyc++;
         if (mem_we || mem_re) begin
            logic [AW+DW:0] e;
            e = exp_txn(txn_cnt);
            if (mem_re && mem_we) order_err++;
            else if (mem_we != e[AW+DW] || mem_addr != e[AW+DW-1:DW] ||
                     (mem_we && mem_wdata != e[DW-1:0])) order_err++;
            if (txn_cnt != 0 && !$onehot(mem_addr)) hot_err++;
            txn_cnt++;
         end
      end
   end

   task automatic run(input int mode, input int a, input int b, input bit poke);
      int exp_p, waited, exp_n;
      fmode = mode; fa = a; fb = b;
      exp_p = ref_first_fail();
      txn_cnt = 0; order_err = 0; hot_err = 0; busy_cyc = 0; mon_on = 1'b1;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      // R9 fail cleared and run begun
      chk(!fail && busy, "R9 fail clear on start", {fail, busy}, 2'b01);
      waited = 0;
      while (!done && waited < 20000) begin
         if (poke && waited == 40) start = 1'b1;
         if (poke && waited == 41) start = 1'b0;
         @(negedge clk); waited++;
      end
      chk(done, "R4 done seen", done, 1);
      @(negedge clk);
      chk(!done, "R4 done one cycle", done, 0);
      repeat (6) @(negedge clk);
      mon_on = 1'b0;
      chk(order_err == 0, "R3 request order", order_err, 0);
      chk(hot_err == 0, "R2 one-hot addresses", hot_err, 0);
      if (exp_p < 0) begin
         chk(!fail, "R4 clean pass", fail, 0);
         chk(txn_cnt == 1 + 3 * NPAIR, "R4 request count", txn_cnt, 1 + 3 * NPAIR);
         chk(busy_cyc == 1 + NPAIR * (3 + RD_LAT), poke ? "R7 busy length with start" :
             "R5 busy length", busy_cyc, 1 + NPAIR * (3 + RD_LAT));
      end else begin
         exp_n = 1 + 3 * (exp_p + 1);
         chk(fail, "R6 fail raised", fail, 1);
         chk(err_addr == AW'(1) << (exp_p / (AW - 1)), "R6 err_addr", err_addr,
             AW'(1) << (exp_p / (AW - 1)));
         chk(err_exp == PAT, "R6 err_exp", err_exp, PAT);
         chk(err_act == ref_act, "R6 err_act", err_act, ref_act);
         chk(txn_cnt == exp_n, "R6 stop after fault", txn_cnt, exp_n);
      end
   endtask

   initial begin
      int a, b;
      void'($urandom(32'd1234));
      for (int k = 0; k < DEPTH; k++) mem[k] = '0;
      for (int k = 0; k < RD_LAT; k++) rpipe[k] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !fail && !mem_we && !mem_re, "R1 idle outputs",
          {busy, done, fail, mem_we, mem_re}, 0);
      chk(err_addr == 0 && err_exp == 0 && err_act == 0, "R1 capture zero",
          err_act, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R8 checked through exp_txn(0) inside the order check
      run(0, 0, 1, 1'b0);
      run(0, 0, 1, 1'b1);              // R7 start while busy
      run(1, 0, 1, 1'b0);              // adjacent low lines, OR
      run(0, 0, 1, 1'b0);              // R9 recovery after fail
      run(2, 0, AW - 1, 1'b0);         // extreme lines, AND
      run(1, AW - 2, AW - 1, 1'b0);    // adjacent high lines
      for (int n = 0; n < 6; n++) begin
         a = $urandom_range(AW - 1, 0);
         b = (a + 1 + $urandom_range(AW - 2, 0)) % AW;
         run(1 + (n % 2), a, b, 1'b0);
      end
      run(0, 0, 1, 1'b0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule